// File: doc/BRIEF.md
# Key-Guarded Configuration Register Bank

This block holds a small bank of configuration words behind a write guard. Word 0 is a lock register: writing a 32-bit magic word to it opens the main protected group, and writing anything else closes it again. Word 1 is a second lock register with its own magic word. It opens a separate group of words and does not depend on the first lock. A window of words at the top of the address space is never guarded. Writes that the guard refuses are dropped without any error, and the stored value is kept.

Software learns the lock state by reading the lock register itself. The read returns 1 when the group is open and 0 when it is closed. The magic word is never stored. Reads take one cycle: the data appears the cycle after the read is issued, and it then holds until the next read.

Word map with the default parameters: 0 is the main lock, 1 is the auxiliary lock, 2 to 7 form the main group, 8 to 11 form the auxiliary group, and 12 to 15 form the open window.

Top module: `keyguard_top`

## Requirements
- R1: After reset both groups are closed, every stored word is zero, and a read of any word returns 0.
- R2: A write of exactly 0xFC600309 to word 0 opens the main group. A read of word 0 issued in the following cycle or later returns 0x00000001.
- R3: A write of any other value to word 0 closes the main group. This includes the complement 0x039FFCF6 and a value one below the key. Word 0 then reads 0x00000000.
- R4: While the main group is closed, a write to words 2 to 7 is dropped, and a later read returns the previous contents.
- R5: While the main group is open, a write to words 2 to 7, including both edge words 2 and 7, is stored and read back unchanged.
- R6: Words 12 to 15 accept writes whether either group is open or closed.
- R7: A write of exactly 0x2003000F to word 1 opens the auxiliary group (words 8 to 11), and word 1 then reads 0x00000001. The two locks are independent: neither magic word affects the other lock, and the main lock gives no write access to words 8 to 11.
- R8: A write of any non-key value to word 1 closes the auxiliary group. Word 1 then reads 0, and later writes to words 8 to 11 are dropped.
- R9: Read data is registered. It shows the addressed word one cycle after readEn. When a write hits the same word in the same cycle, the read returns the contents from before that write. While readEn is low, readData holds its value.
- R10: The lock registers store no data. A read of word 0 or word 1 returns only the status value 0 or 1, whatever was last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| writeEn | input | 1 | Write strobe for one cycle |
| readEn | input | 1 | Read strobe for one cycle |
| addr | input | ADDR_W | Word index |
| writeData | input | DATA_W | Data to write |
| readData | output | DATA_W | Registered read data |

## Verification
The bench writes to each zone under every combination of the two lock states. A value that was dropped and a value that was stored therefore give different readbacks. The lock registers are driven with several values: the exact keys, the complement, a value one below the key, and each group's key sent to the other lock. These tell an exact compare apart from a partial compare and show whether the two locks are independent. A read and a write to the same word in one cycle separates read-before-write behaviour from read-after-write behaviour. Idle stretches after a read show whether readData holds its value.

// File: rtl/keyguard_pkg.sv
package keyguard_pkg;

  localparam logic [31:0] MAIN_KEY = 32'hFC600309;
  localparam logic [31:0] AUX_KEY  = 32'h2003000F;

  typedef enum logic [1:0] {
    ZONE_LOCK,
    ZONE_MAIN,
    ZONE_AUX,
    ZONE_OPEN
  } zone_t;

  // Strobes passed from the control module to the datapath
  typedef struct packed {
    logic commit;    // the current write may be stored
    logic mainOpen;  // main group open
    logic auxOpen;   // auxiliary group open
  } guard_strobe_t;

endpackage

// File: rtl/keyguard_ctrl.sv
module keyguard_ctrl
  import keyguard_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int AUX_BASE  = 8,
  parameter int OPEN_BASE = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              writeEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] writeData,
  output guard_strobe_t     strobe
);

  localparam logic [ADDR_W-1:0] MAIN_IDX  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] AUX_IDX   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] FIRST_ST  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] AUX_LO    = ADDR_W'(AUX_BASE);
  localparam logic [ADDR_W-1:0] OPEN_LO   = ADDR_W'(OPEN_BASE);
  localparam logic [DATA_W-1:0] MAIN_WORD = DATA_W'(MAIN_KEY);
  localparam logic [DATA_W-1:0] AUX_WORD  = DATA_W'(AUX_KEY);

  logic  mainOpenQ;
  logic  auxOpenQ;
  zone_t zone;

  // Lock flags: every write to a lock word re-evaluates that lock
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mainOpenQ <= 1'b0;
      auxOpenQ  <= 1'b0;
    end else if (writeEn) begin
      if (addr == MAIN_IDX) mainOpenQ <= (writeData == MAIN_WORD);
      if (addr == AUX_IDX)  auxOpenQ  <= (writeData == AUX_WORD);
    end
  end

  always_comb begin
    if (addr < FIRST_ST)      zone = ZONE_LOCK;
    else if (addr >= OPEN_LO) zone = ZONE_OPEN;
    else if (addr >= AUX_LO)  zone = ZONE_AUX;
    else                      zone = ZONE_MAIN;
  end

  always_comb begin
    strobe.mainOpen = mainOpenQ;
    strobe.auxOpen  = auxOpenQ;
    unique case (zone)
      ZONE_OPEN: strobe.commit = writeEn;
      ZONE_MAIN: strobe.commit = writeEn & mainOpenQ;
      ZONE_AUX:  strobe.commit = writeEn & auxOpenQ;
      default:   strobe.commit = 1'b0;
    endcase
  end

endmodule

// File: rtl/keyguard_regs.sv
module keyguard_regs
  import keyguard_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              readEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] writeData,
  input  guard_strobe_t     strobe,
  output logic [DATA_W-1:0] readData
);

  localparam int NUM_WORDS = 1 << ADDR_W;
  localparam int FIRST_ST  = 2;

  logic [DATA_W-1:0] words [NUM_WORDS];

  for (genvar g = 0; g < NUM_WORDS; g++) begin : gWord
    if (g < FIRST_ST) begin : gLock
      assign words[g] = '0;
    end else begin : gStore
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rstN) q <= '0;
        else if (strobe.commit && addr == ADDR_W'(g)) q <= writeData;
      end
      assign words[g] = q;
    end
  end

  // Read port: status for the lock words, storage for all others
  always_ff @(posedge clk) begin
    if (!rstN) begin
      readData <= '0;
    end else if (readEn) begin
      if (addr == ADDR_W'(0))      readData <= DATA_W'(strobe.mainOpen);
      else if (addr == ADDR_W'(1)) readData <= DATA_W'(strobe.auxOpen);
      else                         readData <= words[addr];
    end
  end

endmodule

// File: rtl/keyguard_top.sv
module keyguard_top
  import keyguard_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int AUX_BASE  = 8,
  parameter int OPEN_BASE = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              writeEn,
  input  logic              readEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] writeData,
  output logic [DATA_W-1:0] readData
);

  guard_strobe_t strobe;

  keyguard_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .AUX_BASE(AUX_BASE), .OPEN_BASE(OPEN_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .writeEn(writeEn), .addr(addr),
    .writeData(writeData), .strobe(strobe)
  );

  keyguard_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rstN(rstN), .readEn(readEn), .addr(addr),
    .writeData(writeData), .strobe(strobe), .readData(readData)
  );

endmodule

// File: rtl/keyguard_chk.sv
module keyguard_chk
  import keyguard_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int AUX_BASE  = 8,
  parameter int OPEN_BASE = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              writeEn,
  input logic              readEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] writeData,
  input logic [DATA_W-1:0] readData,
  input guard_strobe_t     strobe
);

  localparam logic [ADDR_W-1:0] AUX_LO  = ADDR_W'(AUX_BASE);
  localparam logic [ADDR_W-1:0] OPEN_LO = ADDR_W'(OPEN_BASE);

  a_r2_unlock: assert property (@(posedge clk) disable iff (!rstN)
    (writeEn && addr == '0 && writeData == DATA_W'(MAIN_KEY)) |=> strobe.mainOpen);

  a_r3_relock: assert property (@(posedge clk) disable iff (!rstN)
    (writeEn && addr == '0 && writeData != DATA_W'(MAIN_KEY)) |=> !strobe.mainOpen);

  a_r4_drop: assert property (@(posedge clk) disable iff (!rstN)
    (writeEn && addr >= ADDR_W'(2) && addr < AUX_LO && !strobe.mainOpen) |-> !strobe.commit);

  a_r6_open_window: assert property (@(posedge clk) disable iff (!rstN)
    (writeEn && addr >= OPEN_LO) |-> strobe.commit);

  a_r7_aux_unlock: assert property (@(posedge clk) disable iff (!rstN)
    (writeEn && addr == ADDR_W'(1) && writeData == DATA_W'(AUX_KEY)) |=> strobe.auxOpen);

  a_r7_main_indep: assert property (@(posedge clk) disable iff (!rstN)
    (!(writeEn && addr == '0)) |=> $stable(strobe.mainOpen));

  a_r8_aux_relock: assert property (@(posedge clk) disable iff (!rstN)
    (writeEn && addr == ADDR_W'(1) && writeData != DATA_W'(AUX_KEY)) |=> !strobe.auxOpen);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !readEn |=> $stable(readData));

  a_r10_status: assert property (@(posedge clk) disable iff (!rstN)
    (readEn && addr == '0) |=> readData == DATA_W'($past(strobe.mainOpen)));

endmodule

bind keyguard_top keyguard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .AUX_BASE(AUX_BASE), .OPEN_BASE(OPEN_BASE)
) u_chk (
  .clk(clk), .rstN(rstN), .writeEn(writeEn), .readEn(readEn), .addr(addr),
  .writeData(writeData), .readData(readData), .strobe(strobe)
);

// File: tb/keyguard_top_tb.sv
module keyguard_top_tb;

  localparam logic [31:0] K_MAIN = 32'hFC600309;
  localparam logic [31:0] K_AUX  = 32'h2003000F;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        writeEn = 1'b0;
  logic        readEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] writeData = '0;
  logic [31:0] readData;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;   // 50 MHz

  keyguard_top u_dut (
    .clk(clk), .rstN(rstN), .writeEn(writeEn), .readEn(readEn),
    .addr(addr), .writeData(writeData), .readData(readData)
  );

  typedef struct {
    logic [31:0] exp;
    int          req;
    int          adr;
  } item_t;

  item_t       sbq[$];
  logic [31:0] mem [16];
  bit          mainU, auxU;
  logic [31:0] lastExp;

  function automatic logic [31:0] modelRead(int a);
    if (a == 0) return {31'b0, mainU};
    if (a == 1) return {31'b0, auxU};
    return mem[a];
  endfunction

  function automatic void modelWrite(int a, logic [31:0] d);
    if (a == 0)       mainU = (d == K_MAIN);
    else if (a == 1)  auxU  = (d == K_AUX);
    else if (a >= 12) mem[a] = d;
    else if (a >= 8)  begin if (auxU)  mem[a] = d; end
    else              begin if (mainU) mem[a] = d; end
  endfunction

  task automatic check(logic [31:0] act, logic [31:0] exp, int req, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic doWrite(int a, logic [31:0] d);
    @(negedge clk);
    writeEn = 1'b1; addr = 4'(a); writeData = d;
    modelWrite(a, d);
    @(negedge clk);
    writeEn = 1'b0;
  endtask

  task automatic doRead(int a, int req);
    item_t it;
    @(negedge clk);
    readEn = 1'b1; addr = 4'(a);
    it.exp = modelRead(a); it.req = req; it.adr = a;
    sbq.push_back(it);
    lastExp = it.exp;
    @(negedge clk);
    readEn = 1'b0;
  endtask

  // Read and write to the same word in one cycle (R9)
  task automatic doReadWrite(int a, logic [31:0] d);
    item_t it;
    @(negedge clk);
    readEn = 1'b1; writeEn = 1'b1; addr = 4'(a); writeData = d;
    it.exp = modelRead(a); it.req = 9; it.adr = a;
    sbq.push_back(it);
    modelWrite(a, d);
    @(negedge clk);
    readEn = 1'b0; writeEn = 1'b0;
  endtask

  // Monitor: a read sampled at a posedge is compared at the next negedge
  bit rdIssued = 0;
  always @(posedge clk) rdIssued <= readEn && rstN;

  always @(negedge clk) begin
    if (rdIssued) begin
      if (sbq.size() == 0) begin
        checks++; fails++;
        $display("FAIL R9 unexpected read data: actual %h expected none", readData);
      end else begin
        item_t it;
        it = sbq.pop_front();
        check(readData, it.exp, it.req, $sformatf("read word %0d", it.adr));
      end
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    mainU = 0; auxU = 0;
    repeat (3) @(negedge clk);
    check(readData, 32'h0, 1, "read data during reset");        // R1
    rstN = 1'b1;

    // R1: reset state of every word
    for (int i = 0; i < 16; i++) doRead(i, 1);

    // R4 dropped while closed, R6 open window while closed
    doWrite(3, 32'hAAAA_5555); doRead(3, 4);
    doWrite(12, 32'h1234_5678); doRead(12, 6);

    // R2 unlock, R5 writes at both edges of the main group
    doWrite(0, K_MAIN); doRead(0, 2);
    doWrite(2, 32'h0BAD_F00D); doRead(2, 5);
    doWrite(7, 32'hC0DE_0007); doRead(7, 5);
    // R7: main lock gives no access to the aux group
    doWrite(8, 32'h8888_8888); doRead(8, 7); doRead(1, 7);
    doWrite(15, 32'hFFFF_0015); doRead(15, 6);

    // R3: a value one below the key closes the group
    doWrite(0, K_MAIN - 1); doRead(0, 3);
    doWrite(4, 32'h4444_4444); doRead(4, 4);
    // R3: complement of the key
    doWrite(0, K_MAIN); doRead(0, 2);
    doWrite(0, ~K_MAIN); doRead(0, 3);
    doWrite(2, 32'hDEAD_0002); doRead(2, 4);

    // R7 independence: keys crossed between the locks
    doWrite(1, K_MAIN); doRead(1, 7);
    doWrite(0, K_AUX);  doRead(0, 7);
    // R7 aux unlock
    doWrite(1, K_AUX); doRead(1, 7); doRead(0, 7);
    doWrite(11, 32'h1111_000B); doRead(11, 7);
    doWrite(5, 32'h5555_0005); doRead(5, 4);
    doWrite(13, 32'h0000_0013); doRead(13, 6);
    // R8 aux relock
    doWrite(1, 32'h0000_0000); doRead(1, 8);
    doWrite(9, 32'h9999_0009); doRead(9, 8);
    doWrite(11, 32'h2222_000B); doRead(11, 8);

    // R10: lock words hold status only
    doWrite(0, K_MAIN); doRead(0, 10);
    doWrite(1, K_AUX);  doRead(1, 10);
    doWrite(1, 32'hFFFF_FFFF); doRead(1, 10);

    // R9: read sees pre-write contents; new value on the next read
    doReadWrite(12, 32'hABCD_EF01); doRead(12, 9);
    repeat (4) @(negedge clk);
    check(readData, lastExp, 9, "read data held while idle");

    repeat (3) @(negedge clk);
    if (sbq.size() != 0) begin
      checks++; fails++;
      $display("FAIL R9 reads left unanswered: actual %0d expected 0", sbq.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog expired: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule